// File: doc/BRIEF.md
# Shared Instruction/Data Word Memory

This block is a single word-organised RAM with two ways in. A processor's instruction fetch unit reaches it through a read-only fetch port. Software loads and stores reach it through a single-cycle bus slave port with byte-lane selects. The fetch port takes a byte address and returns the addressed 32-bit word together with a ready flag. The bus port takes a word address and answers every request in one clock. Its acknowledge is permanently high.

The array is split into two regions. Word indices below `INSTR_WORDS` form the instruction region, and the rest, up to `DEPTH`, form the data region. A bus access to the instruction region in a cycle where fetch is enabled has priority. Such an access is served normally, but in the next cycle it drops the fetch ready flag and freezes the fetched word. Bus accesses to the data region never disturb fetch. The array has no reset and no file preload. Software fills it through the bus port.

Top module: `shared_imem_dmem`

## Requirements
- R1: `busAck` is 1 in every cycle, with or without a request and during reset, and `faultOut` is always 0.
- R2: A valid read is `busStb`=1, `busCyc`=1 and `busWe`=0. One clock after a valid read, `busRdData` holds the stored word at index `busAdr[7:0]` (default `DEPTH`=256), with the lanes whose select is 0 forced to zero. Select bit k maps to data bits 8k+7:8k.
- R3: A valid write (`busStb`=1, `busCyc`=1, `busWe`=1) updates only the lanes whose `busSel` bit is 1, at that clock edge. The other lanes of the word keep their old bytes whatever `busWrData` holds there. A read in the next cycle returns the new bytes.
- R4: One clock after any cycle without a valid read, `busRdData` is zero. Such cycles include idle cycles, writes, and a strobe without cycle or a cycle without strobe. A request lacking strobe or cycle also writes nothing.
- R5: With `fetchEn`=1 and no conflicting bus access, one clock later `fetchData` is the word at index `fetchAddr[9:2]` and `fetchReady` is 1.
- R6: A valid bus access whose index is below `INSTR_WORDS` (default 128), made in a cycle with `fetchEn`=1, is a conflict. One clock after a conflict, `fetchReady` is 0, `fetchData` keeps its previous value, and the bus access is still carried out as in R2 and R3.
- R7: A valid bus access whose index is at or above `INSTR_WORDS`, made together with a fetch, leaves `fetchReady` at 1. The fetched word is delivered as in R5.
- R8: With `fetchEn`=0, one clock later `fetchData` keeps its value and `fetchReady` is 1, even during a bus access to the instruction region.
- R9: Synchronous active-high reset clears `fetchData` and `busRdData` to zero and sets `fetchReady` to 1 one clock later. The memory contents are kept through reset.
- R10: Address bits above the index are ignored. This covers `busAdr` bits above 7, and `fetchAddr` bits above 9 and below 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetchAddr | input | 32 | Fetch byte address |
| fetchEn | input | 1 | Fetch read enable |
| fetchData | output | 32 | Fetched word |
| fetchReady | output | 1 | Fetch ready flag, low while a conflict stalls fetch |
| busAdr | input | 30 | Bus word address |
| busWrData | input | 32 | Bus write data |
| busWe | input | 1 | Bus write enable (0 = read) |
| busSel | input | 4 | Bus byte-lane selects |
| busStb | input | 1 | Bus strobe |
| busCyc | input | 1 | Bus cycle |
| busRdData | output | 32 | Bus read data, lane-masked |
| busAck | output | 1 | Bus acknowledge, always high |
| faultOut | output | 1 | Fault flag, tied low |

## Verification
A fetch and a bus access can fall in the same cycle. Whether they collide depends only on where the bus index falls relative to `INSTR_WORDS`. The bench holds `fetchEn` high while issuing bus reads and writes on both sides of that boundary, including the last instruction word and the first data word. It also issues a long pseudo-random mix of both ports. A behavioural model predicts, for every clock, whether the ready flag drops, whether the fetched word freezes, and what masked data the bus returns. The bus side of a colliding access is judged by reading the written word back afterwards.

// File: rtl/shared_mem_pkg.sv
package shared_mem_pkg;

  // Strobes passed from the control to the datapath each cycle
  typedef struct packed {
    logic rdEn;      // valid bus read this cycle
    logic wrEn;      // valid bus write this cycle
    logic fetchLoad; // fetch register captures a new word
  } memStrobes_t;

endpackage

// File: rtl/shared_mem_ctrl.sv
module shared_mem_ctrl
  import shared_mem_pkg::*;
#(
  parameter int DEPTH       = 256,
  parameter int INSTR_WORDS = 128,
  localparam int IDX_W      = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetchEn,
  input  logic [IDX_W-1:0] busIdx,
  input  logic             busWe,
  input  logic             busStb,
  input  logic             busCyc,
  output memStrobes_t      strb,
  output logic             fetchReady
);

  localparam logic [IDX_W-1:0] INSTR_LIM = IDX_W'(INSTR_WORDS);

  logic busValid;
  logic hitsInstr;
  logic conflict;
  logic stallQ;

  assign busValid  = busStb && busCyc;
  assign hitsInstr = busIdx < INSTR_LIM;
  assign conflict  = busValid && hitsInstr && fetchEn;

  always_comb begin
    strb           = '0;
    strb.rdEn      = busValid && !busWe;
    strb.wrEn      = busValid && busWe;
    strb.fetchLoad = fetchEn && !conflict;
  end

  always_ff @(posedge clk) begin
    if (rst) stallQ <= 1'b0;
    else     stallQ <= conflict;
  end

  assign fetchReady = !stallQ;

  AST_CONFLICT_STALLS: assert property (@(posedge clk) disable iff (rst)
    (busStb && busCyc && fetchEn && (busIdx < INSTR_LIM)) |=> !fetchReady); // R6

  AST_DATA_REGION_FREE: assert property (@(posedge clk) disable iff (rst)
    (busStb && busCyc && !(busIdx < INSTR_LIM)) |=> fetchReady); // R7

  AST_NO_FETCH_READY: assert property (@(posedge clk) disable iff (rst)
    !fetchEn |=> fetchReady); // R8

endmodule

// File: rtl/shared_mem_dpath.sv
module shared_mem_dpath
  import shared_mem_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  memStrobes_t       strb,
  input  logic [LANES-1:0]  laneSel,
  input  logic [IDX_W-1:0]  busIdx,
  input  logic [IDX_W-1:0]  fetchIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] fetchData,
  output logic [DATA_W-1:0] busRdData
);

  logic [DATA_W-1:0] memArray [DEPTH];
  logic [DATA_W-1:0] laneMask;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneMask[g*8 +: 8] = {8{laneSel[g]}};

    AST_UNSEL_LANE_ZERO: assert property (@(posedge clk) disable iff (rst)
      (strb.rdEn && !laneSel[g]) |=> (busRdData[g*8 +: 8] == 8'h00)); // R2
  end

  // Byte-lane write, no reset on the array
  always_ff @(posedge clk) begin
    if (strb.wrEn) begin
      for (int l = 0; l < LANES; l++) begin
        if (laneSel[l]) memArray[busIdx][l*8 +: 8] <= wrData[l*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            busRdData <= '0;
    else if (strb.rdEn) busRdData <= memArray[busIdx] & laneMask;
    else                busRdData <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst)                 fetchData <= '0;
    else if (strb.fetchLoad) fetchData <= memArray[fetchIdx];
  end

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !strb.rdEn |=> (busRdData == '0)); // R4

  AST_FETCH_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !strb.fetchLoad |=> $stable(fetchData)); // R6

endmodule

// File: rtl/shared_imem_dmem.sv
module shared_imem_dmem
  import shared_mem_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int FETCH_AW    = 32,
  parameter int BUS_AW      = 30,
  parameter int DEPTH       = 256,
  parameter int INSTR_WORDS = 128,
  localparam int IDX_W      = $clog2(DEPTH),
  localparam int LANES      = DATA_W / 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [FETCH_AW-1:0] fetchAddr,
  input  logic                fetchEn,
  output logic [DATA_W-1:0]   fetchData,
  output logic                fetchReady,
  input  logic [BUS_AW-1:0]   busAdr,
  input  logic [DATA_W-1:0]   busWrData,
  input  logic                busWe,
  input  logic [LANES-1:0]    busSel,
  input  logic                busStb,
  input  logic                busCyc,
  output logic [DATA_W-1:0]   busRdData,
  output logic                busAck,
  output logic                faultOut
);

  memStrobes_t      strb;
  logic [IDX_W-1:0] busIdx;
  logic [IDX_W-1:0] fetchIdx;

  assign busIdx   = busAdr[IDX_W-1:0];
  assign fetchIdx = fetchAddr[IDX_W+1:2];
  assign busAck   = 1'b1;
  assign faultOut = 1'b0;

  shared_mem_ctrl #(
    .DEPTH       (DEPTH),
    .INSTR_WORDS (INSTR_WORDS)
  ) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .fetchEn    (fetchEn),
    .busIdx     (busIdx),
    .busWe      (busWe),
    .busStb     (busStb),
    .busCyc     (busCyc),
    .strb       (strb),
    .fetchReady (fetchReady)
  );

  shared_mem_dpath #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) dpath_i (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .laneSel   (busSel),
    .busIdx    (busIdx),
    .fetchIdx  (fetchIdx),
    .wrData    (busWrData),
    .fetchData (fetchData),
    .busRdData (busRdData)
  );

endmodule

// File: tb/shared_imem_dmem_tb.sv
module shared_imem_dmem_tb_top;

  localparam int DEPTH = 256;
  localparam int INSTR = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetchAddr = '0;
  logic        fetchEn = 1'b0;
  logic [31:0] fetchData;
  logic        fetchReady;
  logic [29:0] busAdr = '0;
  logic [31:0] busWrData = '0;
  logic        busWe = 1'b0;
  logic [3:0]  busSel = '0;
  logic        busStb = 1'b0;
  logic        busCyc = 1'b0;
  logic [31:0] busRdData;
  logic        busAck;
  logic        faultOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk; // 50 MHz

  shared_imem_dmem dut_i (
    .clk(clk), .rst(rst), .fetchAddr(fetchAddr), .fetchEn(fetchEn),
    .fetchData(fetchData), .fetchReady(fetchReady), .busAdr(busAdr),
    .busWrData(busWrData), .busWe(busWe), .busSel(busSel), .busStb(busStb),
    .busCyc(busCyc), .busRdData(busRdData), .busAck(busAck), .faultOut(faultOut)
  );

  function automatic logic [31:0] pat(int i);
    logic [7:0] b;
    b = 8'(i);
    return {b, b ^ 8'h5A, ~b, b + 8'd3};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, updated on each rising edge
  logic [31:0] refMem [DEPTH];
  logic [31:0] expFetch = '0;
  logic [31:0] expRd = '0;
  logic        expReady = 1'b1;
  string       fetchTag = "R9";
  string       rdTag = "R9";
  bit          armed = 0;

  always @(posedge clk) begin
    int idx, fIdx;
    bit valid, conflict;
    logic [31:0] mask, word;
    armed = 1;
    idx   = int'(busAdr[7:0]);
    fIdx  = int'(fetchAddr[9:2]);
    valid = busStb && busCyc;
    mask  = {{8{busSel[3]}}, {8{busSel[2]}}, {8{busSel[1]}}, {8{busSel[0]}}};
    if (rst) begin
      expFetch = '0; expRd = '0; expReady = 1'b1;
      fetchTag = "R9"; rdTag = "R9";
    end else begin
      conflict = valid && (idx < INSTR) && fetchEn;
      if (valid && !busWe) begin expRd = refMem[idx] & mask; rdTag = "R2"; end
      else begin expRd = '0; rdTag = "R4"; end
      expReady = !conflict;
      if (!fetchEn) fetchTag = "R8";
      else if (conflict) fetchTag = "R6";
      else if (valid) fetchTag = "R7";
      else fetchTag = "R5";
      if (fetchEn && !conflict) expFetch = refMem[fIdx];
    end
    if (valid && busWe) begin
      word = refMem[idx];
      for (int l = 0; l < 4; l++)
        if (busSel[l]) word[l*8 +: 8] = busWrData[l*8 +: 8];
      refMem[idx] = word;
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      chk("R1 ack", {31'b0, busAck}, 32'd1);
      chk("R1 fault", {31'b0, faultOut}, 32'd0);
      chk({fetchTag, " ready"}, {31'b0, fetchReady}, {31'b0, expReady});
      chk({fetchTag, " fetch"}, fetchData, expFetch);
      chk({rdTag, " rdata"}, busRdData, expRd);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle();
    busStb = 0; busCyc = 0; busWe = 0; busSel = '0; busWrData = '0;
  endtask

  task automatic busReq(int idx, bit we, logic [3:0] sel, logic [31:0] d);
    busAdr = 30'(idx); busWe = we; busSel = sel; busWrData = d;
    busStb = 1; busCyc = 1;
  endtask

  initial begin
    logic [15:0] lfsr;
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 0;
    // Preload through the bus port
    for (int i = 0; i < DEPTH; i++) begin
      busReq(i, 1, 4'hF, pat(i)); @(negedge clk);
    end
    idle(); @(negedge clk); @(negedge clk);
    // R5 fetch sweep
    fetchEn = 1;
    for (int i = 0; i < 20; i++) begin
      fetchAddr = 32'(i * 4); @(negedge clk);
    end
    // R7 bus reads and writes in the data region during fetch
    busReq(200, 0, 4'b1000, '0); fetchAddr = 32'd80; @(negedge clk);
    chk("R7 rd lane3", busRdData, {pat(200)[31:24], 24'h0});
    busReq(INSTR, 0, 4'b0101, '0); @(negedge clk);
    busReq(INSTR, 1, 4'b0010, 32'h1111_2222); @(negedge clk);
    // R3 directed: single lane write then read back
    busReq(200, 1, 4'b0100, 32'hAA35_AAAA); @(negedge clk);
    busReq(200, 0, 4'b0100, '0); @(negedge clk);
    chk("R3 written lane", busRdData, 32'h0035_0000);
    busReq(200, 0, 4'b1111, '0); @(negedge clk);
    chk("R3 other lanes kept", busRdData, {pat(200)[31:24], 8'h35, pat(200)[15:0]});
    // R6 conflicts in the instruction region, including the last word
    busReq(INSTR - 1, 0, 4'b0010, '0); fetchAddr = 32'd84; @(negedge clk);
    chk("R6 ready low", {31'b0, fetchReady}, 32'd0);
    busReq(5, 1, 4'b0100, 32'hAA35_AAAA); @(negedge clk);
    busReq(5, 0, 4'b1111, '0); @(negedge clk);
    idle(); @(negedge clk);
    chk("R6 write served", busRdData, 32'h0);
    // R8 fetch disabled with instruction-region access
    fetchEn = 0; busReq(5, 0, 4'b0100, '0); @(negedge clk);
    chk("R8 ready high", {31'b0, fetchReady}, 32'd1);
    chk("R6 write landed", busRdData, 32'h0035_0000);
    // R4 strobe without cycle and cycle without strobe write nothing
    fetchEn = 1;
    busReq(210, 1, 4'hF, 32'hDEAD_BEEF); busCyc = 0; @(negedge clk);
    busReq(210, 1, 4'hF, 32'hDEAD_BEEF); busStb = 0; @(negedge clk);
    busReq(210, 0, 4'hF, '0); @(negedge clk);
    chk("R4 no write", busRdData, pat(210));
    // R10 aliasing of upper/lower address bits
    busReq(0, 0, 4'hF, '0); busAdr = {22'h3FFFFF, 8'd200};
    fetchAddr = 32'hABCD_0000 | (32'd10 << 2) | 32'd3; @(negedge clk);
    chk("R10 bus alias", busRdData, {pat(200)[31:24], 8'h35, pat(200)[15:0]});
    chk("R10 fetch alias", fetchData, pat(10));
    // R9 mid-run reset keeps memory
    idle(); rst = 1; @(negedge clk); @(negedge clk);
    chk("R9 fetch cleared", fetchData, 32'h0);
    rst = 0; busReq(210, 0, 4'hF, '0); @(negedge clk);
    chk("R9 memory kept", busRdData, pat(210));
    // Pseudo-random mix of both ports
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      fetchEn = lfsr[0] | lfsr[1];
      fetchAddr = {lfsr[3:0], lfsr[15:4], lfsr[9:0], lfsr[5:4]} ^ 32'(n);
      busStb = lfsr[2] | lfsr[6];
      busCyc = lfsr[3] | lfsr[7];
      busWe = lfsr[8] & lfsr[11];
      busSel = lfsr[15:12] ^ 4'(n);
      busAdr = {lfsr[13:0], lfsr[15:0]} ^ 30'(n * 7);
      busWrData = {lfsr, lfsr ^ 16'(n)};
      @(negedge clk);
    end
    idle(); fetchEn = 0; @(negedge clk); @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule